// File: doc/BRIEF.md
# Inter-core mailbox messaging unit

The mailbox joins two processor cores, called side A and side B, that run on one shared clock. Each side reaches the unit through its own small register bus: a select, a write strobe, a word address, write data, and read data that follows the address within the same cycle. Each side owns a bank of outgoing message slots. A word written into outgoing slot n on one side becomes readable in incoming slot n on the other side. A status word on each side shows which outgoing slots are still unread and which incoming slots hold a word.

Besides messages, each side drives a short flag field toward its partner. A change to that field takes a fixed number of cycles to reach the other side. While the change is in flight, the writer sees a busy bit, and further changes to the field are refused. Each side can also raise general-purpose interrupt requests and one non-maskable request at its partner. A request stays pending until the partner acknowledges it, and until then the requester reads it back as 1.

Each side has one maskable interrupt output, gated by per-slot receive enables and per-request interrupt enables. Each side also has a separate non-maskable output.

Top module: `icmb_top`

## Requirements
- R1: Each side has this word map: outgoing slot n at address n, incoming slot n at address 4+n, status at 8, control at 9. A write to outgoing slot n on one side makes the written word readable at incoming slot n on the other side from the next cycle. The same write sets the reader's status bit 27-n and clears the writer's status bit 31-n. A write to a slot that is still occupied replaces its word.
- R2: Status word layout: bit 31-n is 1 when outgoing slot n is empty; bit 27-n is 1 when incoming slot n is full; bit 23-g is a pending general request g from the partner; bit 19 is a pending non-maskable request from the partner; bit 18 is the own flag-update busy bit; bits 2:0 are the partner's flags. After reset the status word of each side is 0xF0000000, its control word is 0 and both interrupt outputs are 0.
- R3: A read of incoming slot n clears the reader's status bit 27-n and sets the sender's status bit 31-n from the next cycle.
- R4: A control write whose bits 2:0 differ from the side's current flags, made while that side's busy bit is 0, sets the busy bit for exactly 2 cycles. The partner's status bits 2:0 keep the old value during those 2 cycles and show the new value in the cycle after.
- R5: A control write made while the busy bit is 1 leaves the flags unchanged: the writer's control bits 2:0 and the partner's status bits 2:0 keep the earlier value. A write of the current flag value does not set the busy bit.
- R6: Writing 1 to control bit 23-g (general request g) or bit 19 (non-maskable) raises the matching pending bit in the partner's status word from the next cycle. While the request is pending, the writer reads that control bit as 1.
- R7: A pending request stays set until the partner writes 1 to the same bit of its status word, which clears it from the next cycle. Writing 0 to the control bit, or 0 to the status bit, has no effect.
- R8: Control bit 27-n enables incoming slot n, and control bit 3+g enables general request g. A side's irq output is 1 exactly when an enabled incoming slot is full or an enabled general request is pending.
- R9: A side's nmi output follows its pending non-maskable bit (status bit 19), whatever the enable bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_sel | input | 1 | Side A bus select |
| a_wr | input | 1 | Side A write strobe (0 = read) |
| a_addr | input | 4 | Side A word address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, valid in the access cycle |
| a_irq | output | 1 | Side A maskable interrupt |
| a_nmi | output | 1 | Side A non-maskable interrupt |
| b_sel | input | 1 | Side B bus select |
| b_wr | input | 1 | Side B write strobe (0 = read) |
| b_addr | input | 4 | Side B word address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, valid in the access cycle |
| b_irq | output | 1 | Side B maskable interrupt |
| b_nmi | output | 1 | Side B non-maskable interrupt |

## Verification
The bench builds the unit with its default parameters: four 32-bit slots per direction, four general requests, a 3-bit flag field and a propagation delay of 2 cycles. With these values every status group has distinct bit positions, and every slot in both directions is reached by random sends and reads, including overwrites of occupied slots and reads of empty ones. The 2-cycle delay is long enough to land a second flag write inside the busy window and to sample the partner's view in each cycle of the update.

// File: rtl/icmb_pkg.sv
`timescale 1ns/1ps
package icmb_pkg;

   // Bit position helpers shared by status and control words.
   // Each group is packed from the top; element 0 takes the highest bit.
   function automatic int te_pos(input int dw, input int n);
      return dw - 1 - n;
   endfunction

   function automatic int rf_pos(input int dw, input int nm, input int n);
      return dw - 1 - nm - n;
   endfunction

   function automatic int gp_pos(input int dw, input int nm, input int g);
      return dw - 1 - 2 * nm - g;
   endfunction

   function automatic int nmi_pos(input int dw, input int nm, input int ng);
      return dw - 1 - 2 * nm - ng;
   endfunction

   function automatic int busy_pos(input int dw, input int nm, input int ng);
      return dw - 2 - 2 * nm - ng;
   endfunction

endpackage

// File: rtl/icmb_chan.sv
`timescale 1ns/1ps
// One direction of the mailbox: source side writes, destination side reads.
module icmb_chan #(
   parameter int NUM_MSG  = 4,
   parameter int DATA_W   = 32,
   parameter int NUM_GIR  = 4,
   parameter int FLAG_W   = 3,
   parameter int FLAG_DLY = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_MSG-1:0]              tx_wr,
   input  logic [DATA_W-1:0]               tx_data,
   input  logic [NUM_MSG-1:0]              rx_rd,
   input  logic                            flg_wr,
   input  logic [FLAG_W-1:0]               flg_data,
   input  logic [NUM_GIR-1:0]              gir_set,
   input  logic                            nmi_set,
   input  logic [NUM_GIR-1:0]              gip_clr,
   input  logic                            nmi_clr,
   output logic [NUM_MSG-1:0]              slot_full,
   output logic [NUM_MSG-1:0][DATA_W-1:0]  slot_data,
   output logic [FLAG_W-1:0]               flg_src,
   output logic                            flg_busy,
   output logic [FLAG_W-1:0]               flg_dst,
   output logic [NUM_GIR-1:0]              gip_pend,
   output logic                            nmi_pend
);

   localparam int CNT_W = (FLAG_DLY > 1) ? $clog2(FLAG_DLY) : 1;
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(FLAG_DLY - 1);

   // Message slots
   for (genvar i = 0; i < NUM_MSG; i++) begin : g_slot
      logic [DATA_W-1:0] word_q;
      logic              full_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '0;
            full_q <= 1'b0;
         end else if (tx_wr[i]) begin
            word_q <= tx_data;
            full_q <= 1'b1;
         end else if (rx_rd[i]) begin
            full_q <= 1'b0;
         end
      end

      assign slot_full[i] = full_q;
      assign slot_data[i] = word_q;
   end

   // Flag propagation with a fixed in-flight window
   logic [CNT_W-1:0] cnt_q;
   logic             flg_take;

   assign flg_take = flg_wr && !flg_busy && (flg_data != flg_src);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flg_src  <= '0;
         flg_dst  <= '0;
         flg_busy <= 1'b0;
         cnt_q    <= '0;
      end else if (flg_take) begin
         flg_src  <= flg_data;
         flg_busy <= 1'b1;
         cnt_q    <= CNT_LOAD;
      end else if (flg_busy) begin
         if (cnt_q == '0) begin
            flg_dst  <= flg_src;
            flg_busy <= 1'b0;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   // Pending requests: set only from idle, cleared only by acknowledge
   logic [NUM_GIR:0] pend_q, pend_set, pend_clr;

   assign pend_set = {nmi_set, gir_set};
   assign pend_clr = {nmi_clr, gip_clr};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~pend_clr) | (~pend_q & pend_set);
   end

   assign gip_pend = pend_q[NUM_GIR-1:0];
   assign nmi_pend = pend_q[NUM_GIR];

endmodule

// File: rtl/icmb_port.sv
`timescale 1ns/1ps
// Register front end of one side: decode, read mux, enables, interrupt.
module icmb_port
   import icmb_pkg::*;
#(
   parameter int NUM_MSG = 4,
   parameter int DATA_W  = 32,
   parameter int NUM_GIR = 4,
   parameter int FLAG_W  = 3,
   parameter int ADDR_W  = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            sel,
   input  logic                            wr,
   input  logic [ADDR_W-1:0]               addr,
   input  logic [DATA_W-1:0]               wdata,
   output logic [DATA_W-1:0]               rdata,
   output logic                            irq,
   output logic                            nmi,
   // outgoing direction state
   input  logic [NUM_MSG-1:0]              out_full,
   input  logic [FLAG_W-1:0]               out_flags,
   input  logic                            out_busy,
   input  logic [NUM_GIR-1:0]              out_gip,
   input  logic                            out_nmi,
   // incoming direction state
   input  logic [NUM_MSG-1:0]              in_full,
   input  logic [NUM_MSG-1:0][DATA_W-1:0]  in_data,
   input  logic [FLAG_W-1:0]               in_flags,
   input  logic [NUM_GIR-1:0]              in_gip,
   input  logic                            in_nmi,
   // requests toward the two directions
   output logic [NUM_MSG-1:0]              tx_wr,
   output logic [DATA_W-1:0]               tx_data,
   output logic [NUM_MSG-1:0]              rx_rd,
   output logic                            flg_wr,
   output logic [FLAG_W-1:0]               flg_data,
   output logic [NUM_GIR-1:0]              gir_set,
   output logic                            nmi_set,
   output logic [NUM_GIR-1:0]              gip_clr,
   output logic                            nmi_clr
);

   localparam int TX_BASE = 0;
   localparam int RX_BASE = NUM_MSG;
   localparam int SR_ADDR = 2 * NUM_MSG;
   localparam int CR_ADDR = 2 * NUM_MSG + 1;
   localparam int NMI_B   = nmi_pos(DATA_W, NUM_MSG, NUM_GIR);
   localparam int BUSY_B  = busy_pos(DATA_W, NUM_MSG, NUM_GIR);

   logic wr_stb, rd_stb, sr_wr, cr_wr;
   logic [NUM_MSG-1:0] rie_q;
   logic [NUM_GIR-1:0] gie_q;
   logic [DATA_W-1:0]  sr_val, cr_val;

   assign wr_stb = sel && wr;
   assign rd_stb = sel && !wr;
   assign sr_wr  = wr_stb && (addr == ADDR_W'(SR_ADDR));
   assign cr_wr  = wr_stb && (addr == ADDR_W'(CR_ADDR));

   for (genvar i = 0; i < NUM_MSG; i++) begin : g_dec
      assign tx_wr[i] = wr_stb && (addr == ADDR_W'(TX_BASE + i));
      assign rx_rd[i] = rd_stb && (addr == ADDR_W'(RX_BASE + i));
   end

   for (genvar g = 0; g < NUM_GIR; g++) begin : g_req
      assign gir_set[g] = cr_wr && wdata[gp_pos(DATA_W, NUM_MSG, g)];
      assign gip_clr[g] = sr_wr && wdata[gp_pos(DATA_W, NUM_MSG, g)];
   end

   assign nmi_set  = cr_wr && wdata[NMI_B];
   assign nmi_clr  = sr_wr && wdata[NMI_B];
   assign tx_data  = wdata;
   assign flg_wr   = cr_wr;
   assign flg_data = wdata[FLAG_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rie_q <= '0;
         gie_q <= '0;
      end else if (cr_wr) begin
         for (int i = 0; i < NUM_MSG; i++) rie_q[i] <= wdata[rf_pos(DATA_W, NUM_MSG, i)];
         for (int g = 0; g < NUM_GIR; g++) gie_q[g] <= wdata[FLAG_W + g];
      end
   end

   always_comb begin
      sr_val = '0;
      for (int i = 0; i < NUM_MSG; i++) begin
         sr_val[te_pos(DATA_W, i)]          = !out_full[i];
         sr_val[rf_pos(DATA_W, NUM_MSG, i)] = in_full[i];
      end
      for (int g = 0; g < NUM_GIR; g++) sr_val[gp_pos(DATA_W, NUM_MSG, g)] = in_gip[g];
      sr_val[NMI_B]        = in_nmi;
      sr_val[BUSY_B]       = out_busy;
      sr_val[FLAG_W-1:0]   = in_flags;
   end

   always_comb begin
      cr_val = '0;
      for (int i = 0; i < NUM_MSG; i++) cr_val[rf_pos(DATA_W, NUM_MSG, i)] = rie_q[i];
      for (int g = 0; g < NUM_GIR; g++) begin
         cr_val[gp_pos(DATA_W, NUM_MSG, g)] = out_gip[g];
         cr_val[FLAG_W + g]                 = gie_q[g];
      end
      cr_val[NMI_B]      = out_nmi;
      cr_val[FLAG_W-1:0] = out_flags;
   end

   always_comb begin
      rdata = '0;
      if (rd_stb) begin
         if (addr == ADDR_W'(SR_ADDR)) begin
            rdata = sr_val;
         end else if (addr == ADDR_W'(CR_ADDR)) begin
            rdata = cr_val;
         end else begin
            for (int i = 0; i < NUM_MSG; i++)
               if (addr == ADDR_W'(RX_BASE + i)) rdata = in_data[i];
         end
      end
   end

   assign irq = (|(in_full & rie_q)) || (|(in_gip & gie_q));
   assign nmi = in_nmi;

endmodule

// File: rtl/icmb_top.sv
`timescale 1ns/1ps
// Two-sided mailbox: side 0 is A, side 1 is B. Direction s carries s -> 1-s.
module icmb_top #(
   parameter int NUM_MSG  = 4,
   parameter int DATA_W   = 32,
   parameter int NUM_GIR  = 4,
   parameter int FLAG_W   = 3,
   parameter int FLAG_DLY = 2,
   parameter int ADDR_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_sel,
   input  logic              a_wr,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [DATA_W-1:0] a_wdata,
   output logic [DATA_W-1:0] a_rdata,
   output logic              a_irq,
   output logic              a_nmi,
   input  logic              b_sel,
   input  logic              b_wr,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [DATA_W-1:0] b_wdata,
   output logic [DATA_W-1:0] b_rdata,
   output logic              b_irq,
   output logic              b_nmi
);

   localparam int USED_BITS = 2 * NUM_MSG + NUM_GIR + 2 + FLAG_W + NUM_GIR;
   localparam int NUM_REGS  = 2 * NUM_MSG + 2;

   if (NUM_MSG < 1 || NUM_GIR < 1 || FLAG_W < 1) begin : g_bad_count
      $error("icmb_top: slot, request and flag counts must be at least 1");
   end
   if (FLAG_DLY < 1) begin : g_bad_dly
      $error("icmb_top: FLAG_DLY must be at least 1");
   end
   if (USED_BITS > DATA_W) begin : g_bad_layout
      $error("icmb_top: status and control fields do not fit in DATA_W");
   end
   if ((1 << ADDR_W) < NUM_REGS) begin : g_bad_addr
      $error("icmb_top: ADDR_W too small for the register map");
   end

   logic              bus_sel   [2];
   logic              bus_wr    [2];
   logic [ADDR_W-1:0] bus_addr  [2];
   logic [DATA_W-1:0] bus_wdata [2];
   logic [DATA_W-1:0] bus_rdata [2];
   logic              bus_irq   [2];
   logic              bus_nmi   [2];

   logic [NUM_MSG-1:0]             tx_wr     [2];
   logic [DATA_W-1:0]              tx_data   [2];
   logic [NUM_MSG-1:0]             rx_rd     [2];
   logic                           flg_wr    [2];
   logic [FLAG_W-1:0]              flg_data  [2];
   logic [NUM_GIR-1:0]             gir_set   [2];
   logic                           nmi_set   [2];
   logic [NUM_GIR-1:0]             gip_clr   [2];
   logic                           nmi_clr   [2];
   logic [NUM_MSG-1:0]             slot_full [2];
   logic [NUM_MSG-1:0][DATA_W-1:0] slot_data [2];
   logic [FLAG_W-1:0]              flg_src   [2];
   logic                           flg_busy  [2];
   logic [FLAG_W-1:0]              flg_dst   [2];
   logic [NUM_GIR-1:0]             gip_pend  [2];
   logic                           nmi_pend  [2];

   assign bus_sel[0]   = a_sel;
   assign bus_wr[0]    = a_wr;
   assign bus_addr[0]  = a_addr;
   assign bus_wdata[0] = a_wdata;
   assign bus_sel[1]   = b_sel;
   assign bus_wr[1]    = b_wr;
   assign bus_addr[1]  = b_addr;
   assign bus_wdata[1] = b_wdata;
   assign a_rdata = bus_rdata[0];
   assign a_irq   = bus_irq[0];
   assign a_nmi   = bus_nmi[0];
   assign b_rdata = bus_rdata[1];
   assign b_irq   = bus_irq[1];
   assign b_nmi   = bus_nmi[1];

   for (genvar s = 0; s < 2; s++) begin : g_side
      icmb_chan #(
         .NUM_MSG(NUM_MSG), .DATA_W(DATA_W), .NUM_GIR(NUM_GIR),
         .FLAG_W(FLAG_W), .FLAG_DLY(FLAG_DLY)
      ) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .tx_wr    (tx_wr[s]),
         .tx_data  (tx_data[s]),
         .rx_rd    (rx_rd[1-s]),
         .flg_wr   (flg_wr[s]),
         .flg_data (flg_data[s]),
         .gir_set  (gir_set[s]),
         .nmi_set  (nmi_set[s]),
         .gip_clr  (gip_clr[1-s]),
         .nmi_clr  (nmi_clr[1-s]),
         .slot_full(slot_full[s]),
         .slot_data(slot_data[s]),
         .flg_src  (flg_src[s]),
         .flg_busy (flg_busy[s]),
         .flg_dst  (flg_dst[s]),
         .gip_pend (gip_pend[s]),
         .nmi_pend (nmi_pend[s])
      );

      icmb_port #(
         .NUM_MSG(NUM_MSG), .DATA_W(DATA_W), .NUM_GIR(NUM_GIR),
         .FLAG_W(FLAG_W), .ADDR_W(ADDR_W)
      ) u_port (
         .clk      (clk),
         .rst_n    (rst_n),
         .sel      (bus_sel[s]),
         .wr       (bus_wr[s]),
         .addr     (bus_addr[s]),
         .wdata    (bus_wdata[s]),
         .rdata    (bus_rdata[s]),
         .irq      (bus_irq[s]),
         .nmi      (bus_nmi[s]),
         .out_full (slot_full[s]),
         .out_flags(flg_src[s]),
         .out_busy (flg_busy[s]),
         .out_gip  (gip_pend[s]),
         .out_nmi  (nmi_pend[s]),
         .in_full  (slot_full[1-s]),
         .in_data  (slot_data[1-s]),
         .in_flags (flg_dst[1-s]),
         .in_gip   (gip_pend[1-s]),
         .in_nmi   (nmi_pend[1-s]),
         .tx_wr    (tx_wr[s]),
         .tx_data  (tx_data[s]),
         .rx_rd    (rx_rd[s]),
         .flg_wr   (flg_wr[s]),
         .flg_data (flg_data[s]),
         .gir_set  (gir_set[s]),
         .nmi_set  (nmi_set[s]),
         .gip_clr  (gip_clr[s]),
         .nmi_clr  (nmi_clr[s])
      );
   end

endmodule

// File: rtl/icmb_chk.sv
`timescale 1ns/1ps
// Property checker for icmb_top, attached by bind.
module icmb_chk #(
   parameter int NUM_MSG  = 4,
   parameter int NUM_GIR  = 4,
   parameter int FLAG_W   = 3,
   parameter int FLAG_DLY = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_MSG-1:0] tx_wr     [2],
   input logic [NUM_MSG-1:0] rx_rd     [2],
   input logic [NUM_MSG-1:0] slot_full [2],
   input logic [FLAG_W-1:0]  flg_src   [2],
   input logic               flg_busy  [2],
   input logic [FLAG_W-1:0]  flg_dst   [2],
   input logic [NUM_GIR-1:0] gir_set   [2],
   input logic               nmi_set   [2],
   input logic [NUM_GIR-1:0] gip_clr   [2],
   input logic               nmi_clr   [2],
   input logic [NUM_GIR-1:0] gip_pend  [2],
   input logic               nmi_pend  [2]
);

   for (genvar s = 0; s < 2; s++) begin : g_dir
      for (genvar i = 0; i < NUM_MSG; i++) begin : g_slot
         // R1
         slot_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tx_wr[s][i] |=> slot_full[s][i]);
         // R3
         slot_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_rd[1-s][i] && !tx_wr[s][i]) |=> !slot_full[s][i]);
      end

      // R4
      flag_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(flg_dst[s]) |-> ($past(flg_busy[s]) && !flg_busy[s]));

      if (FLAG_DLY > 1) begin : g_long
         // R4
         flag_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flg_busy[s]) |=> flg_busy[s]);
      end

      // R5
      flag_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
         flg_busy[s] |=> $stable(flg_src[s]));

      for (genvar g = 0; g < NUM_GIR; g++) begin : g_gir
         // R6
         gir_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (gir_set[s][g] && !gip_pend[s][g]) |=> gip_pend[s][g]);
         // R7
         gir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (gip_pend[s][g] && !gip_clr[1-s][g]) |=> gip_pend[s][g]);
         // R7
         gir_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!gip_pend[s][g] && !gir_set[s][g]) |=> !gip_pend[s][g]);
      end

      // R6
      nmi_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (nmi_set[s] && !nmi_pend[s]) |=> nmi_pend[s]);
      // R7
      nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (nmi_pend[s] && !nmi_clr[1-s]) |=> nmi_pend[s]);
   end

endmodule

bind icmb_top icmb_chk #(
   .NUM_MSG(NUM_MSG), .NUM_GIR(NUM_GIR), .FLAG_W(FLAG_W), .FLAG_DLY(FLAG_DLY)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tx_wr    (tx_wr),
   .rx_rd    (rx_rd),
   .slot_full(slot_full),
   .flg_src  (flg_src),
   .flg_busy (flg_busy),
   .flg_dst  (flg_dst),
   .gir_set  (gir_set),
   .nmi_set  (nmi_set),
   .gip_clr  (gip_clr),
   .nmi_clr  (nmi_clr),
   .gip_pend (gip_pend),
   .nmi_pend (nmi_pend)
);

// File: tb/tb_icmb_top.sv
`timescale 1ns/1ps
module tb_icmb_top;

   localparam logic [3:0] A_SR = 4'd8;
   localparam logic [3:0] A_CR = 4'd9;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel   [2];
   logic        wr    [2];
   logic [3:0]  addr  [2];
   logic [31:0] wdata [2];
   logic [31:0] rdata [2];
   logic        irq   [2];
   logic        nmi   [2];

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // bench model
   bit          mfull [2][4];
   logic [31:0] mdata [2][4];
   bit   [3:0]  mgip  [2];
   bit          mnmi  [2];
   bit   [2:0]  mflg  [2];

   always #2.5 clk = ~clk;

   icmb_top dut (
      .clk(clk), .rst_n(rst_n),
      .a_sel(sel[0]), .a_wr(wr[0]), .a_addr(addr[0]), .a_wdata(wdata[0]),
      .a_rdata(rdata[0]), .a_irq(irq[0]), .a_nmi(nmi[0]),
      .b_sel(sel[1]), .b_wr(wr[1]), .b_addr(addr[1]), .b_wdata(wdata[1]),
      .b_rdata(rdata[1]), .b_irq(irq[1]), .b_nmi(nmi[1])
   );

   function automatic logic [31:0] exp_sr(input int s);
      logic [31:0] v = '0;
      for (int n = 0; n < 4; n++) begin
         v[31-n] = !mfull[s][n];
         v[27-n] = mfull[1-s][n];
         v[23-n] = mgip[1-s][n];
      end
      v[19]  = mnmi[1-s];
      v[2:0] = mflg[1-s];
      return v;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input int s, input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      sel[s] = 1'b1; wr[s] = 1'b1; addr[s] = a; wdata[s] = d;
      @(negedge clk);
      sel[s] = 1'b0; wr[s] = 1'b0;
   endtask

   task automatic bus_rd(input int s, input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      sel[s] = 1'b1; wr[s] = 1'b0; addr[s] = a;
      #1 d = rdata[s];
      @(negedge clk);
      sel[s] = 1'b0;
   endtask

   // read without a clock edge (status and control only)
   task automatic peek(input int s, input logic [3:0] a, output logic [31:0] d);
      sel[s] = 1'b1; wr[s] = 1'b0; addr[s] = a;
      #1 d = rdata[s];
      sel[s] = 1'b0;
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R1 act=running exp=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      void'($urandom(32'h0000_5EED));
      for (int s = 0; s < 2; s++) begin
         sel[s] = 0; wr[s] = 0; addr[s] = 0; wdata[s] = 0;
         mgip[s] = 0; mnmi[s] = 0; mflg[s] = 0;
         for (int n = 0; n < 4; n++) begin mfull[s][n] = 0; mdata[s][n] = 0; end
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 reset state
      peek(0, A_SR, r); chk("R2 reset A status", r, 32'hF000_0000);
      peek(1, A_SR, r); chk("R2 reset B status", r, 32'hF000_0000);
      peek(0, A_CR, r); chk("R2 reset A control", r, 32'h0);
      chk("R2 reset irq/nmi", {30'd0, irq[0] | irq[1], nmi[0] | nmi[1]}, 32'h0);

      // R1 directed: A slot 2 to B
      bus_wr(0, 4'd2, 32'hDEAD_BEEF); mfull[0][2] = 1; mdata[0][2] = 32'hDEAD_BEEF;
      peek(1, A_SR, r); chk("R1 B full bit 25", r, exp_sr(1));
      peek(0, A_SR, r); chk("R1 A empty bit 29 clear", r, exp_sr(0));
      bus_rd(1, 4'd6, r); chk("R1 B reads slot 2", r, 32'hDEAD_BEEF);
      mfull[0][2] = 0;
      // R3
      peek(1, A_SR, r); chk("R3 B full cleared", r, exp_sr(1));
      peek(0, A_SR, r); chk("R3 A empty set", r, exp_sr(0));

      // R1 R3 random traffic in both directions
      for (int it = 0; it < 400; it++) begin
         int s, op, n;
         logic [31:0] d;
         s  = int'($urandom % 2);
         op = int'($urandom % 3);
         n  = int'($urandom % 4);
         if (op == 0) begin
            d = $urandom;
            bus_wr(s, 4'(n), d);
            mfull[s][n] = 1; mdata[s][n] = d;
            peek(1-s, A_SR, r); chk("R1 random send status", r, exp_sr(1-s));
         end else if (op == 1) begin
            bus_rd(s, 4'(4 + n), r);
            if (mfull[1-s][n]) chk("R1 random receive word", r, mdata[1-s][n]);
            mfull[1-s][n] = 0;
            peek(1-s, A_SR, r); chk("R3 random sender status", r, exp_sr(1-s));
         end else begin
            @(negedge clk);
         end
         peek(s, A_SR, r); chk("R2 random own status", r, exp_sr(s));
      end
      // drain everything
      for (int s = 0; s < 2; s++)
         for (int n = 0; n < 4; n++) begin
            bus_rd(s, 4'(4 + n), r);
            mfull[1-s][n] = 0;
         end
      peek(0, A_SR, r); chk("R3 drained A", r, exp_sr(0));

      // R4 flag timing
      bus_wr(0, A_CR, 32'd5);
      peek(0, A_SR, r); chk("R4 busy cycle 1", {31'd0, r[18]}, 32'd1);
      peek(1, A_SR, r); chk("R4 old flags cycle 1", {29'd0, r[2:0]}, 32'd0);
      @(negedge clk);
      peek(0, A_SR, r); chk("R4 busy cycle 2", {31'd0, r[18]}, 32'd1);
      peek(1, A_SR, r); chk("R4 old flags cycle 2", {29'd0, r[2:0]}, 32'd0);
      @(negedge clk);
      peek(0, A_SR, r); chk("R4 busy cleared", {31'd0, r[18]}, 32'd0);
      peek(1, A_SR, r); chk("R4 new flags", {29'd0, r[2:0]}, 32'd5);
      mflg[0] = 3'd5;

      // R5 write during busy ignored
      bus_wr(0, A_CR, 32'd6);
      bus_wr(0, A_CR, 32'd1);
      repeat (4) @(negedge clk);
      mflg[0] = 3'd6;
      peek(1, A_SR, r); chk("R5 far flags keep first", r, exp_sr(1));
      peek(0, A_CR, r); chk("R5 own flags keep first", r, 32'd6);
      bus_wr(0, A_CR, 32'd6);
      peek(0, A_SR, r); chk("R5 same value no busy", {31'd0, r[18]}, 32'd0);

      // R6 R7 R8 general request 1 from A to B
      bus_wr(0, A_CR, 32'd6 | (32'd1 << 22)); mgip[0][1] = 1;
      peek(1, A_SR, r); chk("R6 B pending set", r, exp_sr(1));
      peek(0, A_CR, r); chk("R6 A reads request", r, 32'd6 | (32'd1 << 22));
      chk("R8 masked request no irq", {31'd0, irq[1]}, 32'd0);
      bus_wr(0, A_CR, 32'd6);
      peek(1, A_SR, r); chk("R7 control zero no effect", r, exp_sr(1));
      bus_wr(1, A_SR, 32'd0);
      peek(1, A_SR, r); chk("R7 status zero no effect", r, exp_sr(1));
      bus_wr(1, A_CR, 32'd1 << 4);
      #1 chk("R8 enabled request irq", {31'd0, irq[1]}, 32'd1);
      chk("R8 A irq quiet", {31'd0, irq[0]}, 32'd0);
      bus_wr(1, A_SR, 32'd1 << 22); mgip[0][1] = 0;
      peek(1, A_SR, r); chk("R7 acknowledged", r, exp_sr(1));
      peek(0, A_CR, r); chk("R7 A reads request done", r, 32'd6);
      #1 chk("R8 irq after ack", {31'd0, irq[1]}, 32'd0);

      // R8 receive enable for slot 0 on B
      bus_wr(1, A_CR, 32'd1 << 27);
      bus_wr(0, 4'd0, 32'h1234_5678);
      #1 chk("R8 slot irq", {31'd0, irq[1]}, 32'd1);
      bus_rd(1, 4'd4, r); chk("R1 slot 0 word", r, 32'h1234_5678);
      #1 chk("R8 slot irq after read", {31'd0, irq[1]}, 32'd0);

      // R9 non-maskable
      bus_wr(0, A_CR, 32'd6 | (32'd1 << 19)); mnmi[0] = 1;
      #1 chk("R9 nmi raised", {30'd0, nmi[1], nmi[0]}, 32'd2);
      chk("R9 nmi not on irq", {31'd0, irq[1]}, 32'd0);
      peek(1, A_SR, r); chk("R6 B nmi pending", r, exp_sr(1));
      bus_wr(1, A_SR, 32'd1 << 19); mnmi[0] = 0;
      #1 chk("R9 nmi cleared", {31'd0, nmi[1]}, 32'd0);
      peek(1, A_SR, r); chk("R7 B status final", r, exp_sr(1));

      done = 1'b1;
      summary();
      $finish;
   end

endmodule